// File: doc/BRIEF.md
# Mode-Controlled Nine-Pin GPIO Port

This block is one general-purpose I/O port of nine pins behind a 16-bit register bus. Each pin owns one bit of a data register and a 2-bit mode code. The mode code decides two things for that pin. It decides whether the pin is driven from the data bit. It also decides whether a read of the data word returns the stored bit or the pin's synchronized input level.

Writes always reach the data register, whatever the mode, but a pin is driven only while its mode is "output". There are two resets. A power-on reset clears the data register and the mode codes. A manual reset clears only the mode codes and keeps the data. Low-power entry and exit have no effect on any register, since the block has no clock gating or state of its own for them.

Address map, with word addresses on `bus_addr`:
- 0 is the data word, with pin n at bit n.
- 1 holds the mode codes of pins 7..0, with pin n at bits 2n+1:2n.
- 2 holds the mode code of pin 8 at bits 1:0.
- 3 reads as zero.

Top module: `mpio_port`

## Requirements
- R1: A power-on reset (`por_rst` high at a clock edge) clears the data register and every mode code. Afterwards address 1 and address 2 read 0, and `pin_oe` is 0.
- R2: A manual reset (`man_rst` high, `por_rst` low) leaves the data register unchanged and ignores any bus write in that cycle. It sets every mode code to 00, so `pin_oe` is 0 after the edge.
- R3: Bits 15:9 of the data word always read 0, and the bits written there are discarded.
- R4: Mode 01 (output) sets the pin's `pin_oe` bit. It drives the data bit on `pin_out`, and a read of the data word returns the stored bit.
- R5: Mode 00 (input) clears `pin_oe` and forces `pin_out` low. A read returns the synchronized pin level. A write still updates the stored bit, which becomes visible once the pin is switched to mode 01.
- R6: Mode 11 (alternate function) behaves like mode 00 at this block's pins and read path. A write still updates the stored bit.
- R7: Mode 10 (reserved) is treated exactly as mode 00: the pin is not driven, and a read returns the pin level.
- R8: `bus_be[0]` enables bits 7:0 and `bus_be[1]` enables bits 15:8 of a write. Bytes without their enable keep their old contents, in both the data word and the mode words.
- R9: A change on `pin_in` shows in the data-word read only after two rising clock edges. After one edge the old level is still returned.
- R10: Mode words read back exactly as written in their valid bits. Bits 15:2 of address 2 read 0, and address 3 reads 0.
- R11: A bus cycle with `bus_sel` or `bus_wr` low changes no register. `pin_out` and `pin_oe` stay constant.
- R12: Read data is combinational. It is valid in the same cycle that `bus_sel` is high, and it is 0 while `bus_sel` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Synchronous active-high power-on reset |
| man_rst | input | 1 | Synchronous active-high manual reset |
| bus_sel | input | 1 | Register select |
| bus_wr | input | 1 | Write strobe, valid with `bus_sel` |
| bus_addr | input | 2 | Word address |
| bus_be | input | 2 | Byte enables for writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, same cycle as select |
| pin_in | input | 9 | Raw pin levels |
| pin_out | output | 9 | Pin drive values |
| pin_oe | output | 9 | Pin drive enables |

## Verification
The bench writes data while pins sit in input, alternate and reserved modes, then switches them to output. A design that dropped writes outside output mode would expose stale data at that point. It places a manual reset between a data write and a readback, which catches a design that treats both resets alike. It samples the read port one edge and two edges after a pin change, so a missing or extra synchronizer stage is visible. Mixed per-pin modes, partial byte enables and all-ones writes to the unused upper bits catch read-mux bit mix-ups, enable bytes that are swapped or ignored, and bits that leak into the padding.

// File: rtl/mpio_pkg.sv
package mpio_pkg;
  typedef enum logic [1:0] {
    MD_IN   = 2'b00,
    MD_OUT  = 2'b01,
    MD_RSVD = 2'b10,
    MD_ALT  = 2'b11
  } pin_mode_e;

  localparam int MODE_BITS = 2;
  localparam int ADDR_DATA = 0;
  localparam int ADDR_MODE0 = 1;
endpackage

// File: rtl/mpio_sync.sv
module mpio_sync #(
  parameter int W      = 9,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mpio_regs.sv
module mpio_regs #(
  parameter int NPIN = 9,
  parameter int BUSW = 16,
  parameter int AW   = 2
) (
  input  logic                               clk,
  input  logic                               por_rst,
  input  logic                               man_rst,
  input  logic                               wr_stb,
  input  logic [AW-1:0]                      addr,
  input  logic [BUSW/8-1:0]                  be,
  input  logic [BUSW-1:0]                    wdata,
  output logic [NPIN-1:0]                    data_q,
  output logic [mpio_pkg::MODE_BITS*NPIN-1:0] mode_q
);
  import mpio_pkg::*;
  localparam int MODE_W = MODE_BITS * NPIN;

  // data register: cleared by power-on reset only
  always_ff @(posedge clk) begin
    if (por_rst) begin
      data_q <= '0;
    end else if (!man_rst && wr_stb && int'(addr) == ADDR_DATA) begin
      for (int i = 0; i < NPIN; i++)
        if (be[i/8]) data_q[i] <= wdata[i];
    end
  end

  // mode codes: cleared by either reset, spread over consecutive words
  always_ff @(posedge clk) begin
    if (por_rst || man_rst) begin
      mode_q <= '0;
    end else if (wr_stb) begin
      for (int j = 0; j < MODE_W; j++)
        if (int'(addr) == ADDR_MODE0 + j / BUSW && be[(j % BUSW) / 8])
          mode_q[j] <= wdata[j % BUSW];
    end
  end
endmodule

// File: rtl/mpio_pin_ctl.sv
module mpio_pin_ctl #(
  parameter int NPIN = 9
) (
  input  logic [mpio_pkg::MODE_BITS*NPIN-1:0] mode_q,
  input  logic [NPIN-1:0]                    data_q,
  input  logic [NPIN-1:0]                    pin_sync,
  output logic [NPIN-1:0]                    rd_bits,
  output logic [NPIN-1:0]                    pin_out,
  output logic [NPIN-1:0]                    pin_oe
);
  import mpio_pkg::*;

  generate
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
      pin_mode_e md;
      logic      drive;
      assign md = pin_mode_e'(mode_q[MODE_BITS*i +: MODE_BITS]);
      always_comb begin
        case (md)
          MD_OUT:  drive = 1'b1;
          MD_IN,
          MD_ALT,
          MD_RSVD: drive = 1'b0;
          default: drive = 1'b0;
        endcase
      end
      assign pin_oe[i]  = drive;
      assign pin_out[i] = drive & data_q[i];
      assign rd_bits[i] = drive ? data_q[i] : pin_sync[i];
    end
  endgenerate
endmodule

// File: rtl/mpio_port.sv
module mpio_port #(
  parameter int NPIN        = 9,
  parameter int BUSW        = 16,
  parameter int AW          = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              por_rst,
  input  logic              man_rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [BUSW/8-1:0] bus_be,
  input  logic [BUSW-1:0]   bus_wdata,
  output logic [BUSW-1:0]   bus_rdata,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_oe
);
  import mpio_pkg::*;
  localparam int MODE_W     = MODE_BITS * NPIN;
  localparam int MODE_WORDS = (MODE_W + BUSW - 1) / BUSW;
  localparam int NWORDS     = 1 + MODE_WORDS;

  logic [NPIN-1:0]              data_q;
  logic [MODE_W-1:0]            mode_q;
  logic [NPIN-1:0]              pin_sync;
  logic [NPIN-1:0]              rd_bits;
  logic [MODE_WORDS*BUSW-1:0]   mode_pad;
  logic [BUSW-1:0]              word_v [NWORDS];
  logic                         wr_stb;

  assign wr_stb = bus_sel & bus_wr;

  mpio_regs #(.NPIN(NPIN), .BUSW(BUSW), .AW(AW)) u_regs (
    .clk(clk), .por_rst(por_rst), .man_rst(man_rst), .wr_stb(wr_stb),
    .addr(bus_addr), .be(bus_be), .wdata(bus_wdata),
    .data_q(data_q), .mode_q(mode_q)
  );

  mpio_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(por_rst | man_rst), .d(pin_in), .q(pin_sync)
  );

  mpio_pin_ctl #(.NPIN(NPIN)) u_ctl (
    .mode_q(mode_q), .data_q(data_q), .pin_sync(pin_sync),
    .rd_bits(rd_bits), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  assign mode_pad  = (MODE_WORDS*BUSW)'(mode_q);
  assign word_v[0] = BUSW'(rd_bits);

  generate
    for (genvar k = 0; k < MODE_WORDS; k++) begin : g_mword
      assign word_v[1+k] = mode_pad[k*BUSW +: BUSW];
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && int'(bus_addr) < NWORDS) bus_rdata = word_v[bus_addr];
  end
endmodule

// File: rtl/mpio_port_chk.sv
module mpio_port_chk #(
  parameter int NPIN = 9,
  parameter int BUSW = 16,
  parameter int AW   = 2
) (
  input logic              clk,
  input logic              por_rst,
  input logic              man_rst,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [AW-1:0]     bus_addr,
  input logic [BUSW/8-1:0] bus_be,
  input logic [BUSW-1:0]   bus_rdata,
  input logic [NPIN-1:0]   pin_out,
  input logic [NPIN-1:0]   pin_oe,
  input logic [NPIN-1:0]   data_q,
  input logic [2*NPIN-1:0] mode_q
);
  logic past_ok = 1'b0;
  always_ff @(posedge clk) past_ok <= 1'b1;

  // R1
  por_clear_chk: assert property (@(posedge clk) disable iff (!past_ok)
    por_rst |=> (data_q == '0 && mode_q == '0 && pin_oe == '0));

  // R2
  man_keep_chk: assert property (@(posedge clk) disable iff (!past_ok)
    (man_rst && !por_rst) |=> ($stable(data_q) && pin_oe == '0));

  // R3
  upper_zero_chk: assert property (@(posedge clk) disable iff (por_rst)
    (bus_sel && bus_addr == '0) |-> (bus_rdata[BUSW-1:NPIN] == '0));

  // R8
  low_byte_keep_chk: assert property (@(posedge clk) disable iff (!past_ok || por_rst || man_rst)
    (bus_sel && bus_wr && bus_addr == '0 && bus_be == 2'b10) |=> (data_q[7:0] == $past(data_q[7:0])));

  // R11
  idle_stable_chk: assert property (@(posedge clk) disable iff (!past_ok || por_rst || man_rst)
    !(bus_sel && bus_wr) |=> ($stable(pin_out) && $stable(pin_oe)));

  // R12
  idle_rdata_chk: assert property (@(posedge clk) disable iff (por_rst)
    !bus_sel |-> (bus_rdata == '0));
endmodule

bind mpio_port mpio_port_chk #(.NPIN(NPIN), .BUSW(BUSW), .AW(AW)) u_chk (
  .clk(clk), .por_rst(por_rst), .man_rst(man_rst), .bus_sel(bus_sel),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_be(bus_be), .bus_rdata(bus_rdata),
  .pin_out(pin_out), .pin_oe(pin_oe), .data_q(data_q), .mode_q(mode_q)
);

// File: tb/sim_mpio_port.sv
`timescale 1ns/1ps
module sim_mpio_port;
  logic        clk = 1'b0;
  logic        por_rst = 1'b1, man_rst = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0, bus_be = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [8:0]  pin_in = '0;
  logic [8:0]  pin_out, pin_oe;
  int total = 0, bad = 0;
  logic [15:0] rv;

  always #4 clk = ~clk;

  mpio_port u0 (
    .clk(clk), .por_rst(por_rst), .man_rst(man_rst), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 v = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic set_modes(input logic [1:0] m);
    wr(2'd1, {8{m}}, 2'b11);
    wr(2'd2, {14'd0, m}, 2'b11);
  endtask

  task automatic settle_pins(input logic [8:0] p);
    @(negedge clk); pin_in = p;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_por;
    set_modes(2'b01); wr(2'd0, 16'h01FF, 2'b11);
    @(negedge clk); por_rst = 1'b1;
    repeat (2) @(negedge clk); por_rst = 1'b0;
    rd(2'd1, rv); chk("R1 mode lo", rv, 16'h0);
    rd(2'd2, rv); chk("R1 mode hi", rv, 16'h0);
    chk("R1 oe", {7'd0, pin_oe}, 16'h0);
    set_modes(2'b01);
    rd(2'd0, rv); chk("R1 data cleared", rv, 16'h0);
  endtask

  task automatic t_output;
    set_modes(2'b01);
    wr(2'd0, 16'h01A5, 2'b11);
    rd(2'd0, rv); chk("R4 read", rv, 16'h01A5);
    chk("R4 oe", {7'd0, pin_oe}, 16'h01FF);
    chk("R4 out", {7'd0, pin_out}, 16'h01A5);
    wr(2'd0, 16'hFFFF, 2'b11);
    rd(2'd0, rv); chk("R3 upper zero", rv, 16'h01FF);
  endtask

  task automatic t_input;
    set_modes(2'b00);
    settle_pins(9'h0C3);
    wr(2'd0, 16'h0155, 2'b11);
    rd(2'd0, rv); chk("R5 pin level", rv, 16'h00C3);
    chk("R5 oe", {7'd0, pin_oe}, 16'h0);
    chk("R5 out", {7'd0, pin_out}, 16'h0);
    set_modes(2'b01);
    rd(2'd0, rv); chk("R5 write kept", rv, 16'h0155);
  endtask

  task automatic t_alt;
    set_modes(2'b11);
    settle_pins(9'h0AA);
    wr(2'd0, 16'h0111, 2'b11);
    rd(2'd0, rv); chk("R6 pin level", rv, 16'h00AA);
    chk("R6 oe", {7'd0, pin_oe}, 16'h0);
    chk("R6 out", {7'd0, pin_out}, 16'h0);
    set_modes(2'b01);
    rd(2'd0, rv); chk("R6 write kept", rv, 16'h0111);
  endtask

  task automatic t_rsvd;
    set_modes(2'b10);
    settle_pins(9'h133);
    wr(2'd0, 16'h00CC, 2'b11);
    rd(2'd0, rv); chk("R7 pin level", rv, 16'h0133);
    chk("R7 oe", {7'd0, pin_oe}, 16'h0);
    set_modes(2'b01);
    rd(2'd0, rv); chk("R7 write kept", rv, 16'h00CC);
  endtask

  task automatic t_mixed;
    // pin0 out, pin1 in, pin2 alt, pin3 reserved, pins 4-7 in, pin8 out
    wr(2'd1, 16'h00B1, 2'b11);
    wr(2'd2, 16'h0001, 2'b11);
    settle_pins(9'h000);
    wr(2'd0, 16'h01FF, 2'b11);
    rd(2'd0, rv); chk("R4 mixed read", rv, 16'h0101);
    chk("R4 mixed oe", {7'd0, pin_oe}, 16'h0101);
    chk("R5 mixed out", {7'd0, pin_out}, 16'h0101);
  endtask

  task automatic t_sync;
    set_modes(2'b00);
    settle_pins(9'h000);
    @(negedge clk); pin_in = 9'h1FF;
    @(negedge clk);
    bus_sel = 1'b1; bus_addr = 2'd0; #1 rv = bus_rdata; bus_sel = 1'b0;
    chk("R9 one edge", rv, 16'h0000);
    @(negedge clk);
    bus_sel = 1'b1; bus_addr = 2'd0; #1 rv = bus_rdata; bus_sel = 1'b0;
    chk("R9 two edges", rv, 16'h01FF);
  endtask

  task automatic t_be;
    set_modes(2'b01);
    wr(2'd0, 16'h0000, 2'b11);
    wr(2'd0, 16'hFFFF, 2'b01);
    rd(2'd0, rv); chk("R8 low byte", rv, 16'h00FF);
    wr(2'd0, 16'hFFFF, 2'b10);
    rd(2'd0, rv); chk("R8 high byte", rv, 16'h01FF);
    wr(2'd0, 16'h0000, 2'b01);
    rd(2'd0, rv); chk("R8 low only", rv, 16'h0100);
    wr(2'd1, 16'h0000, 2'b10);
    rd(2'd1, rv); chk("R8 mode byte", rv, 16'h0055);
  endtask

  task automatic t_man;
    set_modes(2'b01);
    wr(2'd0, 16'h00A5, 2'b11);
    @(negedge clk); man_rst = 1'b1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 16'h0000; bus_be = 2'b11;
    @(negedge clk); man_rst = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_be = '0;
    chk("R2 oe cleared", {7'd0, pin_oe}, 16'h0);
    rd(2'd1, rv); chk("R2 mode cleared", rv, 16'h0);
    set_modes(2'b01);
    rd(2'd0, rv); chk("R2 data kept", rv, 16'h00A5);
  endtask

  task automatic t_map;
    wr(2'd1, 16'h1234, 2'b11);
    wr(2'd2, 16'hFFFF, 2'b11);
    rd(2'd1, rv); chk("R10 mode lo", rv, 16'h1234);
    rd(2'd2, rv); chk("R10 mode hi", rv, 16'h0003);
    rd(2'd3, rv); chk("R10 addr3", rv, 16'h0000);
  endtask

  task automatic t_nowr;
    set_modes(2'b01);
    wr(2'd0, 16'h005A, 2'b11);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = 16'h01FF; bus_be = 2'b11;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
    chk("R11 out", {7'd0, pin_out}, 16'h005A);
    rd(2'd0, rv); chk("R11 data", rv, 16'h005A);
    @(negedge clk); bus_addr = 2'd0; #1;
    chk("R12 idle read", bus_rdata, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    por_rst = 1'b0;
    t_por();
    t_output();
    t_input();
    t_alt();
    t_rsvd();
    t_mixed();
    t_sync();
    t_be();
    t_man();
    t_map();
    t_nowr();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule